// File: doc/BRIEF.md
# SD Card Command-Line Engine

This block runs the host side of the single-bit command wire of an SD card bus. A start strobe hands it a 6-bit command index, a 32-bit argument and a response kind. The block then shifts a 48-bit command frame onto the wire, one bit on each SD clock-enable tick. It computes the frame's 7-bit checksum while the frame goes out.

After the end bit the block releases the wire. If a reply is expected, it listens for the reply's start bit, captures a short (48-bit) or long (136-bit) reply, and judges it. The verdict is one of four codes: success, no reply in time, checksum mismatch, or wrong index field.

The surrounding controller generates the SD clock and passes its rising-edge strobe in as `sd_tick`. It sequences card initialisation on its own and reads the payload and status on the `done` pulse.

Top module: `sdcmd_engine`

## Requirements
- R1: A frame consists of 48 bits, output most significant first, one bit per `sd_tick`, starting with the first tick after the start strobe is accepted. The layout is bit 0 = 0, bit 1 = 1, bits 2..7 = the command index, bits 8..39 = the argument with its most significant bit first, bits 40..46 = the checksum, and bit 47 = 1. `cmd_oe` is high for all 48 bits.
- R2: The checksum is the remainder of bits 0..39 under the polynomial x^7 + x^3 + 1, with a zero starting value. For example, command 0 with argument 0 gives the frame 0x400000000095, and command 8 with argument 0x1AA gives 0x48000001AA87.
- R3: After the end bit, `cmd_oe` is low until the next frame. When `rsp_kind` = 0 (no reply), `done` rises in the cycle that follows the end-bit tick, with `status` = 0 and both payloads zero.
- R4: The reply begins at the first 0 sampled on `cmd_in` at a tick after the end bit. A start bit sampled on any of the first TIMEOUT_TICKS ticks is accepted, including the last of them.
- R5: If all TIMEOUT_TICKS sampled ticks read 1, `done` rises one cycle after the last of them, with `status` = 1 and both payloads zero. After that, further activity on `cmd_in` has no effect.
- R6: For `rsp_kind` = 1 (short reply), `rsp_short` equals reply bits 8..39, and `status` is 0 when every check passes. The status codes are 0 success, 1 timeout, 2 checksum error and 3 index error.
- R7: For a short reply, a checksum computed over reply bits 0..39 must equal bits 40..46; otherwise `status` = 2. A checksum error wins over an index error.
- R8: For a short reply, the index field (bits 2..7) must equal the command index, or `status` = 3. The single exception is command 41, which accepts any index.
- R9: For `rsp_kind` = 2 (short reply without checks), `status` = 0 and `rsp_short` is bits 8..39, whatever the reply's checksum and index field contain.
- R10: For `rsp_kind` = 3 (long reply, 136 bits), `rsp_long` equals bits 8..127. A checksum over bits 8..127 must equal bits 128..134, or `status` = 2. If the checksum is good but bits 2..7 are not all ones, `status` = 3.
- R11: `busy` is high from the accepted start until `done`. A start strobe while `busy` is high is ignored. `done` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sd_tick | input | 1 | One-cycle strobe marking each SD clock bit time |
| start | input | 1 | Begin a command (taken only when idle) |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_kind | input | 2 | 0 none, 1 short, 2 short unchecked, 3 long |
| cmd_in | input | 1 | Sampled level of the command wire |
| cmd_out | output | 1 | Value driven onto the command wire |
| cmd_oe | output | 1 | Drive enable of the command wire |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Verdict of the last command |
| rsp_short | output | 32 | Payload of a short reply |
| rsp_long | output | 120 | Payload of a long reply |

## Verification
The hardest cases to reach are replies that are well formed except for one defect: a checksum that is off by one bit, an index that names another command, or a start bit that lands on the very last tick of the wait window. The bench acts as the card. It watches `cmd_oe` and counts ticks from the end bit, so it can place a start bit on any chosen tick. It builds each reply with an independent long-division checksum and can flip the lowest checksum bit. This lets it combine a correct or broken checksum with a matching or foreign index, on each reply kind.

// File: rtl/sdcmd_pkg.sv
// Package: shared types and frame geometry of the SD command engine.
// Assumes: frame lengths fixed by the bus; only the timeout is tunable.
package sdcmd_pkg;
    localparam int SHORT_LEN  = 48;
    localparam int LONG_LEN   = 136;
    localparam int HEAD_LEN   = 40;
    localparam int CRC_W      = 7;
    localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;
    localparam logic [5:0] EXEMPT_IDX = 6'd41;
    localparam logic [5:0] LONG_IDX   = 6'h3F;

    typedef enum logic [1:0] {
        RSP_NONE        = 2'd0,
        RSP_SHORT       = 2'd1,
        RSP_SHORT_NOCRC = 2'd2,
        RSP_LONG        = 2'd3
    } rsp_kind_e;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_TIMEOUT = 2'd1,
        ST_CRC     = 2'd2,
        ST_INDEX   = 2'd3
    } status_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_SEND = 2'd1,
        S_RESP = 2'd2
    } eng_state_e;
endpackage

// File: rtl/sdcmd_crc7.sv
// Module: bit-serial CRC-7 accumulator.
// Assumes: one message bit per enabled cycle, MSB first; clr wins over en.
module sdcmd_crc7
    import sdcmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);
    logic fb;

    // feedback term: incoming bit against the register's top bit
    always_comb fb = din ^ crc[CRC_W-1];

    // shift the remainder one bit per enabled cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc <= '0;
        end else if (clr) begin
            crc <= '0;
        end else if (en) begin
            crc <= {crc[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & CRC_POLY);
        end
    end
endmodule

// File: rtl/sdcmd_tx.sv
// Module: command frame serialiser.
// Assumes: load only while not running; bits advance on tick; the wire is
// driven from load until the end bit's tick.
module sdcmd_tx
    import sdcmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        load,
    input  logic [5:0]  idx,
    input  logic [31:0] arg,
    output logic        cmd_out,
    output logic        cmd_oe,
    output logic        last
);
    logic [HEAD_LEN-1:0] head;
    logic [5:0]          bpos;
    logic                running;
    logic [CRC_W-1:0]    crc;
    logic                cur_bit;
    logic                crc_en;

    // position counter and head shifter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head    <= '0;
            bpos    <= '0;
            running <= 1'b0;
        end else if (load) begin
            head    <= {2'b01, idx, arg};
            bpos    <= '0;
            running <= 1'b1;
        end else if (running && tick) begin
            if (bpos == 6'(SHORT_LEN - 1)) begin
                running <= 1'b0;
            end else begin
                bpos <= bpos + 6'd1;
            end
            if (bpos < 6'(HEAD_LEN)) begin
                head <= {head[HEAD_LEN-2:0], 1'b0};
            end
        end
    end

    // checksum accumulates only the 40 header bits
    always_comb crc_en = running && tick && (bpos < 6'(HEAD_LEN));

    sdcmd_crc7 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (load),
        .en    (crc_en),
        .din   (head[HEAD_LEN-1]),
        .crc   (crc)
    );

    // select header, checksum or end bit for the current position
    always_comb begin
        cur_bit = 1'b1;
        if (bpos < 6'(HEAD_LEN)) begin
            cur_bit = head[HEAD_LEN-1];
        end else begin
            for (int j = 0; j < CRC_W; j++) begin
                if (bpos == 6'(HEAD_LEN + CRC_W - 1 - j)) cur_bit = crc[j];
            end
        end
    end

    // wire outputs and end-of-frame pulse
    always_comb begin
        cmd_oe  = running;
        cmd_out = running ? cur_bit : 1'b1;
        last    = running && tick && (bpos == 6'(SHORT_LEN - 1));
    end

    // R1
    first_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_oe) |-> !cmd_out);

    // R1
    end_bit_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_oe) |-> $past(cmd_out));
endmodule

// File: rtl/sdcmd_rx.sv
// Module: reply watcher and capture register with timeout.
// Assumes: arm pulses on the end-bit tick; the line is sampled on ticks;
// the end bit of a reply is counted but not stored.
module sdcmd_rx
    import sdcmd_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         arm,
    input  logic         long_rsp,
    input  logic         line,
    output logic         fin,
    output logic         tout,
    output logic         active,
    output logic         crc_match,
    output logic [5:0]   idx_field,
    output logic [31:0]  pay_short,
    output logic [119:0] pay_long
);
    localparam int TW = $clog2(TIMEOUT_TICKS) + 1;
    localparam int SW = LONG_LEN - 3;

    logic              waiting;
    logic              capturing;
    logic              is_long;
    logic [7:0]        cnt;
    logic [TW-1:0]     tcnt;
    logic [SW-1:0]     shreg;
    logic [CRC_W-1:0]  crc;
    logic [7:0]        last_idx;
    logic              in_crc;
    logic              crc_en;

    // index of the final reply bit for the armed length
    always_comb last_idx = is_long ? 8'(LONG_LEN - 1) : 8'(SHORT_LEN - 1);

    // which reply bits feed the checksum
    always_comb in_crc = is_long ? ((cnt >= 8'd8) && (cnt < 8'(LONG_LEN - 8)))
                                 : (cnt < 8'(SHORT_LEN - 8));

    // wait for start bit, count timeout, shift reply bits in
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waiting   <= 1'b0;
            capturing <= 1'b0;
            is_long   <= 1'b0;
            cnt       <= '0;
            tcnt      <= '0;
            shreg     <= '0;
            fin       <= 1'b0;
            tout      <= 1'b0;
        end else begin
            fin  <= 1'b0;
            tout <= 1'b0;
            if (arm) begin
                waiting   <= 1'b1;
                capturing <= 1'b0;
                is_long   <= long_rsp;
                cnt       <= '0;
                tcnt      <= '0;
                shreg     <= '0;
            end else if (waiting && tick) begin
                if (!line) begin
                    waiting   <= 1'b0;
                    capturing <= 1'b1;
                    cnt       <= 8'd1;
                    shreg     <= {shreg[SW-2:0], 1'b0};
                end else if (tcnt == TW'(TIMEOUT_TICKS - 1)) begin
                    waiting <= 1'b0;
                    fin     <= 1'b1;
                    tout    <= 1'b1;
                    shreg   <= '0;
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
            end else if (capturing && tick) begin
                if (cnt == last_idx) begin
                    capturing <= 1'b0;
                    fin       <= 1'b1;
                end else begin
                    shreg <= {shreg[SW-2:0], line};
                    cnt   <= cnt + 8'd1;
                end
            end
        end
    end

    // checksum runs over the covered span of the reply
    always_comb crc_en = capturing && tick && in_crc;

    sdcmd_crc7 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (arm),
        .en    (crc_en),
        .din   (line),
        .crc   (crc)
    );

    // field extraction from the capture register
    always_comb begin
        active    = waiting || capturing;
        crc_match = (crc == shreg[CRC_W-1:0]);
        idx_field = is_long ? shreg[132:127] : shreg[44:39];
        pay_short = shreg[38:7];
        pay_long  = shreg[126:7];
    end

    // R5
    tout_has_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tout |-> fin);
endmodule

// File: rtl/sdcmd_engine.sv
// Module: SD command engine top; sequences send, reply wait and verdict.
// Assumes: sd_tick is a single-cycle strobe from the SD clock generator;
// start is ignored while busy; results hold until the next done.
module sdcmd_engine
    import sdcmd_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sd_tick,
    input  logic         start,
    input  logic [5:0]   cmd_idx,
    input  logic [31:0]  cmd_arg,
    input  logic [1:0]   rsp_kind,
    input  logic         cmd_in,
    output logic         cmd_out,
    output logic         cmd_oe,
    output logic         busy,
    output logic         done,
    output logic [1:0]   status,
    output logic [31:0]  rsp_short,
    output logic [119:0] rsp_long
);
    eng_state_e   state;
    rsp_kind_e    kind_q;
    logic [5:0]   idx_q;
    status_e      st_q;
    logic         tx_load;
    logic         tx_last;
    logic         rx_arm;
    logic         rx_fin;
    logic         rx_tout;
    logic         rx_active;
    logic         crc_match;
    logic [5:0]   idx_field;
    logic [31:0]  pay_short;
    logic [119:0] pay_long;
    status_e      verdict;
    logic [31:0]  next_short;
    logic [119:0] next_long;

    // handshakes between sequencer and datapaths
    always_comb begin
        busy    = (state != S_IDLE);
        tx_load = (state == S_IDLE) && start;
        rx_arm  = (state == S_SEND) && tx_last && (kind_q != RSP_NONE);
        status  = st_q;
    end

    sdcmd_tx u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (sd_tick),
        .load    (tx_load),
        .idx     (cmd_idx),
        .arg     (cmd_arg),
        .cmd_out (cmd_out),
        .cmd_oe  (cmd_oe),
        .last    (tx_last)
    );

    sdcmd_rx #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (sd_tick),
        .arm       (rx_arm),
        .long_rsp  (kind_q == RSP_LONG),
        .line      (cmd_in),
        .fin       (rx_fin),
        .tout      (rx_tout),
        .active    (rx_active),
        .crc_match (crc_match),
        .idx_field (idx_field),
        .pay_short (pay_short),
        .pay_long  (pay_long)
    );

    // verdict and payload selection per reply kind
    always_comb begin
        verdict    = ST_OK;
        next_short = '0;
        next_long  = '0;
        if (rx_tout) begin
            verdict = ST_TIMEOUT;
        end else begin
            case (kind_q)
                RSP_SHORT: begin
                    next_short = pay_short;
                    if (!crc_match) verdict = ST_CRC;
                    else if ((idx_field != idx_q) && (idx_q != EXEMPT_IDX)) verdict = ST_INDEX;
                end
                RSP_SHORT_NOCRC: begin
                    next_short = pay_short;
                end
                RSP_LONG: begin
                    next_long = pay_long;
                    if (!crc_match) verdict = ST_CRC;
                    else if (idx_field != LONG_IDX) verdict = ST_INDEX;
                end
                default: ;
            endcase
        end
    end

    // command sequencer and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            kind_q    <= RSP_NONE;
            idx_q     <= '0;
            done      <= 1'b0;
            st_q      <= ST_OK;
            rsp_short <= '0;
            rsp_long  <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        kind_q <= rsp_kind_e'(rsp_kind);
                        idx_q  <= cmd_idx;
                        state  <= S_SEND;
                    end
                end
                S_SEND: begin
                    if (tx_last) begin
                        if (kind_q == RSP_NONE) begin
                            done      <= 1'b1;
                            st_q      <= ST_OK;
                            rsp_short <= '0;
                            rsp_long  <= '0;
                            state     <= S_IDLE;
                        end else begin
                            state <= S_RESP;
                        end
                    end
                end
                S_RESP: begin
                    if (rx_fin) begin
                        done      <= 1'b1;
                        st_q      <= verdict;
                        rsp_short <= next_short;
                        rsp_long  <= next_long;
                        state     <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R3
    released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oe |-> !rx_active);

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    idle_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R5
    timeout_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (status == 2'd1)) |-> ((rsp_short == '0) && (rsp_long == '0)));

    // R9
    unchecked_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (kind_q == RSP_SHORT_NOCRC)) |-> (status <= 2'd1));
endmodule

// File: tb/sdcmd_engine_tb.sv
module sdcmd_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TO   = 16;
    localparam int DIV  = 3;

    logic         clk;
    logic         rst_n;
    logic         sd_tick;
    logic         start;
    logic [5:0]   cmd_idx;
    logic [31:0]  cmd_arg;
    logic [1:0]   rsp_kind;
    logic         cmd_in;
    logic         cmd_out;
    logic         cmd_oe;
    logic         busy;
    logic         done;
    logic [1:0]   status;
    logic [31:0]  rsp_short;
    logic [119:0] rsp_long;

    int n_checks = 0;
    int n_fail   = 0;
    int divc     = 0;
    bit finished = 0;

    logic [47:0] fr;
    int          wait_ticks;
    bit          oe_low_in_frame;
    bit          oe_high_in_reply;
    bit          got_done;

    sdcmd_engine #(.TIMEOUT_TICKS(TO)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sd_tick   (sd_tick),
        .start     (start),
        .cmd_idx   (cmd_idx),
        .cmd_arg   (cmd_arg),
        .rsp_kind  (rsp_kind),
        .cmd_in    (cmd_in),
        .cmd_out   (cmd_out),
        .cmd_oe    (cmd_oe),
        .busy      (busy),
        .done      (done),
        .status    (status),
        .rsp_short (rsp_short),
        .rsp_long  (rsp_long)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    // remainder by long division, message in m[n-1:0]
    function automatic logic [6:0] crc_div(input logic [127:0] m, input int n);
        logic [134:0] v;
        v = {m, 7'b0};
        for (int i = n + 6; i >= 7; i--) begin
            if (v[i]) v[i -: 8] = v[i -: 8] ^ 8'h89;
        end
        return v[6:0];
    endfunction

    function automatic logic [47:0] exp_frame(input logic [5:0] idx, input logic [31:0] arg);
        logic [39:0] h;
        h = {2'b01, idx, arg};
        return {h, crc_div({88'b0, h}, 40), 1'b1};
    endfunction

    function automatic logic [47:0] mk_short(input logic [5:0] ridx, input logic [31:0] pay, input bit bad);
        logic [39:0] h;
        h = {2'b00, ridx, pay};
        return {h, crc_div({88'b0, h}, 40) ^ {6'b0, bad}, 1'b1};
    endfunction

    function automatic logic [135:0] mk_long(input logic [5:0] ridx, input logic [119:0] pay, input bit bad);
        return {2'b00, ridx, pay, crc_div({8'b0, pay}, 120) ^ {6'b0, bad}, 1'b1};
    endfunction

    task automatic step();
        @(negedge clk);
        divc    = (divc == DIV - 1) ? 0 : divc + 1;
        sd_tick = (divc == 0);
    endtask

    task automatic check_eq(input string req, input string what,
                            input logic [135:0] act, input logic [135:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // issue one command and play the card side
    task automatic run_cmd(input logic [1:0] kind, input logic [5:0] idx, input logic [31:0] arg,
                           input int delay, input logic [135:0] rb, input int rlen, input bit poke);
        int  got;
        int  ticks;
        int  n;
        bit  poked;
        got = 0; poked = 0;
        oe_low_in_frame = 0; oe_high_in_reply = 0;
        step();
        start = 1'b1; cmd_idx = idx; cmd_arg = arg; rsp_kind = kind;
        step();
        start = 1'b0;
        while (got < 48) begin
            if (sd_tick) begin
                fr[47 - got] = cmd_out;
                if (!cmd_oe) oe_low_in_frame = 1;
                got++;
            end
            if (poke && got == 10 && !poked) begin
                start = 1'b1; cmd_idx = ~idx; cmd_arg = ~arg; rsp_kind = 2'd3; poked = 1;
            end else begin
                start = 1'b0;
            end
            step();
        end
        start = 1'b0;
        if (kind != 2'd0) begin
            ticks = 0;
            while (ticks < delay + rlen) begin
                if (sd_tick) begin
                    if (cmd_oe) oe_high_in_reply = 1;
                    cmd_in = (ticks < delay) ? 1'b1 : rb[rlen - 1 - (ticks - delay)];
                    ticks++;
                end
                step();
            end
            cmd_in = 1'b1;
        end
        wait_ticks = 0; n = 0;
        while (!done && n < 2000) begin
            if (sd_tick) wait_ticks++;
            step();
            n++;
        end
        got_done = done;
        if (got_done) begin
            step();
            check_eq("R11", "done lasts one cycle", {135'b0, done}, 136'd0);
            wait_ticks = wait_ticks;
        end
    endtask

    task automatic short_case(input string req, input logic [1:0] kind, input logic [5:0] idx,
                              input logic [5:0] ridx, input logic [31:0] pay, input bit bad,
                              input int delay, input logic [1:0] exp_st);
        run_cmd(kind, idx, 32'h1234_0000 ^ {26'b0, idx}, delay,
                {88'b0, mk_short(ridx, pay, bad)}, 48, 0);
        check_eq(req, "done after short reply", {135'b0, got_done}, 136'd1);
        check_eq(req, "short status", {134'b0, status}, {134'b0, exp_st});
        check_eq(req, "short payload", {104'b0, rsp_short}, {104'b0, pay});
        check_eq("R3", "oe released during reply", {135'b0, oe_high_in_reply}, 136'd0);
    endtask

    initial begin
        logic [119:0] lp;
        rst_n = 1'b0; start = 1'b0; cmd_idx = '0; cmd_arg = '0; rsp_kind = '0;
        cmd_in = 1'b1; sd_tick = 1'b0;
        repeat (5) step();
        rst_n = 1'b1;
        step();
        // reset state (R3, R11)
        check_eq("R3", "reset oe", {135'b0, cmd_oe}, 136'd0);
        check_eq("R3", "reset idle line", {135'b0, cmd_out}, 136'd1);
        check_eq("R11", "reset busy", {135'b0, busy}, 136'd0);
        check_eq("R11", "reset done", {135'b0, done}, 136'd0);

        // known frames (R1, R2) with no reply (R3)
        run_cmd(2'd0, 6'd0, 32'h0, 0, '0, 0, 0);
        check_eq("R2", "cmd0 frame", {88'b0, fr}, {88'b0, 48'h40_0000_0000_95});
        check_eq("R3", "no-reply done at once", wait_ticks, 0);
        check_eq("R3", "no-reply status", {134'b0, status}, 136'd0);
        run_cmd(2'd0, 6'd8, 32'h0000_01AA, 0, '0, 0, 0);
        check_eq("R2", "cmd8 frame", {88'b0, fr}, {88'b0, 48'h48_0000_01AA_87});
        run_cmd(2'd0, 6'd17, 32'h0, 0, '0, 0, 0);
        check_eq("R2", "cmd17 frame", {88'b0, fr}, {88'b0, 48'h51_0000_0000_55});

        // every command index (R1, R2)
        for (int i = 0; i < 64; i++) begin
            logic [31:0] a;
            a = (32'h9E37_79B9 * i) ^ 32'h5A5A_0F0F;
            run_cmd(2'd0, i[5:0], a, 0, '0, 0, 0);
            check_eq("R1", "frame bits", {88'b0, fr}, {88'b0, exp_frame(i[5:0], a)});
            check_eq("R1", "oe held through frame", {135'b0, oe_low_in_frame}, 136'd0);
        end

        // short replies
        short_case("R6", 2'd1, 6'd17, 6'd17, 32'h0000_0900, 0, 3, 2'd0);
        short_case("R7", 2'd1, 6'd17, 6'd17, 32'hCAFE_F00D, 1, 2, 2'd2);
        short_case("R7", 2'd1, 6'd13, 6'd12, 32'h0000_0001, 1, 1, 2'd2);
        short_case("R8", 2'd1, 6'd13, 6'd12, 32'h8000_0000, 0, 1, 2'd3);
        short_case("R8", 2'd1, 6'd41, 6'd63, 32'h80FF_8000, 0, 2, 2'd0);
        short_case("R9", 2'd2, 6'd41, 6'd63, 32'h00FF_8000, 1, 2, 2'd0);
        short_case("R9", 2'd2, 6'd5,  6'd0,  32'h1234_5678, 1, 0, 2'd0);
        short_case("R4", 2'd1, 6'd55, 6'd55, 32'hA5A5_5A5A, 0, 0, 2'd0);
        short_case("R4", 2'd1, 6'd7,  6'd7,  32'h0F0F_F0F0, 0, TO - 1, 2'd0);

        // long replies (R10)
        lp = {32'hDEAD_BEEF, 32'h0123_4567, 32'h89AB_CDEF, 24'h5A5A5A};
        run_cmd(2'd3, 6'd2, 32'h0, 4, mk_long(6'h3F, lp, 0), 136, 0);
        check_eq("R10", "long status", {134'b0, status}, 136'd0);
        check_eq("R10", "long payload", {16'b0, rsp_long}, {16'b0, lp});
        run_cmd(2'd3, 6'd9, 32'h0, 1, mk_long(6'h3F, ~lp, 1), 136, 0);
        check_eq("R10", "long bad checksum", {134'b0, status}, 136'd2);
        run_cmd(2'd3, 6'd10, 32'h0, 1, mk_long(6'h3E, lp, 0), 136, 0);
        check_eq("R10", "long bad index", {134'b0, status}, 136'd3);

        // timeout boundary (R5)
        run_cmd(2'd1, 6'd3, 32'h0, 0, '0, 0, 0);
        check_eq("R5", "timeout status", {134'b0, status}, 136'd1);
        check_eq("R5", "timeout tick count", wait_ticks, TO);
        check_eq("R5", "timeout payloads", {rsp_short, rsp_long}, '0);
        for (int k = 0; k < 3 * DIV * 5; k++) begin
            cmd_in = 1'b0;
            step();
            if (done || busy) begin
                check_eq("R5", "late start bit ignored", {134'b0, done, busy}, 136'd0);
            end
        end
        cmd_in = 1'b1;
        check_eq("R5", "status kept after late bit", {134'b0, status}, 136'd1);

        // start while busy ignored (R11)
        run_cmd(2'd0, 6'd24, 32'h0BAD_F00D, 0, '0, 0, 1);
        check_eq("R11", "frame unchanged by second start", {88'b0, fr},
                 {88'b0, exp_frame(6'd24, 32'h0BAD_F00D)});
        check_eq("R11", "kind unchanged by second start", wait_ticks, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule